// File: doc/BRIEF.md
# MSK Transmit Modulator with Bit Timing

This block turns a serial bit stream into a minimum-shift-keyed tone sequence, produced as a stream of signed digital sine samples. A phase accumulator advances once per sample period. A 64-entry quarter-wave table turns its value into an 8-bit sample. The sample period is a fixed number of master-clock enable pulses; at the default of 384 pulses of a 3.6864 MHz master clock, the sample rate is 9600 Hz. A data 1 is sent as the mark tone (1200 Hz). A data 0 is sent as the space tone: 1800 Hz in the slow 1200 bit/s mode, or 2400 Hz in the fast 2400 bit/s mode. In both modes the two tones differ by half the bit rate, and the phase is never reset between bits, so the waveform is continuous.

The block also drives a transmit timing clock back to the data source. This clock falls at the start of every bit period and rises at its midpoint. The data source changes its bit after a falling edge. The block captures the bit on the rising edge and sends it during the following bit period. While the enable input is low, the timing clock is parked high, the accumulator is cleared and the output sits at zero.

Top module: `msk_tx_mod`

## Requirements
- R1: While `txEn` is low, and during reset, `txClk` is 1 and `sampleOut` is 0, whatever `mclkEn`, `rateSel` and `txData` do.
- R2: A bit period lasts 8 sample periods when `rateSel` is 0 (slow) and 4 sample periods when it is 1 (fast). A sample period is SAMPLE_DIV cycles in which `mclkEn` is high.
- R3: A data 1 advances the phase by 32 steps per sample, out of 256 steps per cycle. This gives 1200 Hz at a 9600 Hz sample rate in both modes.
- R4: A data 0 advances the phase by 48 steps per sample in slow mode (1800 Hz) and by 64 steps per sample in fast mode (2400 Hz).
- R5: `txClk` falls at the start of each bit period and rises after half the bit period's sample periods. The value on `txData` at the rising edge is the bit sent in the next bit period. Changes to `txData` after that edge have no effect.
- R6: The phase is carried across bit boundaries without reset. At each bit boundary the output equals the sine of the phase accumulated over all earlier bits.
- R7: `sampleOut` is a two's-complement value equal to round(127·sin(2π·φ/256)) within 1 LSB, where φ is the 8-bit phase. It never takes the value -128.
- R8: After `txEn` rises, `txClk` falls on the next clock. The first bit period sends the mark tone starting from phase 0. The first rising edge of `txClk` comes within half a bit period.
- R9: A change of `rateSel` takes effect only at the next bit boundary. Both the length of the bit period and the choice of space tone follow the value present at that boundary.
- R10: While `mclkEn` is low, neither `sampleOut` nor `txClk` changes during an enabled run.
- R11: Dropping `txEn` clears the phase, so the next run starts again at phase 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mclkEn | input | 1 | One-cycle strobe per master-clock period |
| txEn | input | 1 | Modulator enable |
| rateSel | input | 1 | 0 = 1200 bit/s, 1 = 2400 bit/s |
| txData | input | 1 | Serial transmit data |
| txClk | output | 1 | Transmit timing clock to the data source |
| sampleOut | output | 8 | Signed sine sample |

## Verification
The bench hunts for phase jumps at bit boundaries. A design that cleared or re-seeded the accumulator per bit would show the wrong sine value at the boundary sample. Rate flips in the middle of a bit target a design that applied the new rate at once; it would produce a short or long bit and a wrong space tone. The bench also flips `txData` just after each rising edge of the timing clock, so a design that sampled the bit at the boundary instead would send the junk value. `mclkEn` is withheld at random, which exposes a bit timer that counts raw clocks. Back-to-back runs catch an accumulator that survives disable.

// File: rtl/msk_tx_pkg.sv
package msk_tx_pkg;
  localparam int PHASE_W        = 8;
  localparam int SAMPLE_W       = 8;
  localparam int AMP            = 2 ** (SAMPLE_W - 1) - 1;
  localparam int PHASE_STEPS    = 2 ** PHASE_W;
  localparam int SPB_SLOW       = 8;
  localparam int SPB_FAST       = SPB_SLOW / 2;
  // one full mark cycle per slow bit; space differs by half the bit rate
  localparam int MARK_INC       = PHASE_STEPS / SPB_SLOW;
  localparam int SPACE_SLOW_INC = MARK_INC * 3 / 2;
  localparam int SPACE_FAST_INC = MARK_INC * 2;

  typedef struct packed {
    logic               clear;
    logic               step;
    logic [PHASE_W-1:0] inc;
  } pathCmd_t;
endpackage

// File: rtl/msk_tx_ctrl.sv
module msk_tx_ctrl
  import msk_tx_pkg::*;
#(
  parameter int SAMPLE_DIV = 384
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     mclkEn,
  input  logic     txEn,
  input  logic     rateSel,
  input  logic     txData,
  output logic     txClk,
  output pathCmd_t cmd
);
  localparam int DIV_W  = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1;
  localparam int SLOT_W = $clog2(SPB_SLOW);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SAMPLE_DIV - 1);

  logic               running;
  logic [DIV_W-1:0]   divCnt;
  logic [SLOT_W-1:0]  slotCnt;
  logic               capBit;
  logic               rateQ;
  logic [PHASE_W-1:0] curInc;
  logic               sampleTick;
  logic [SLOT_W-1:0]  lastSlot;
  logic [SLOT_W-1:0]  midSlot;
  logic [SLOT_W-1:0]  halfSlot;

  function automatic logic [PHASE_W-1:0] incFor(input logic bitVal, input logic fast);
    if (bitVal)    return PHASE_W'(MARK_INC);
    else if (fast) return PHASE_W'(SPACE_FAST_INC);
    else           return PHASE_W'(SPACE_SLOW_INC);
  endfunction

  always_comb begin
    lastSlot   = rateQ ? SLOT_W'(SPB_FAST - 1)     : SLOT_W'(SPB_SLOW - 1);
    halfSlot   = rateQ ? SLOT_W'(SPB_FAST / 2)     : SLOT_W'(SPB_SLOW / 2);
    midSlot    = rateQ ? SLOT_W'(SPB_FAST / 2 - 1) : SLOT_W'(SPB_SLOW / 2 - 1);
    sampleTick = running && mclkEn && (divCnt == DIV_LAST);
    txClk      = !running || (slotCnt >= halfSlot);
    cmd.clear  = !txEn;
    cmd.step   = sampleTick;
    cmd.inc    = curInc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      divCnt  <= '0;
      slotCnt <= '0;
      capBit  <= 1'b1;
      rateQ   <= 1'b0;
      curInc  <= PHASE_W'(MARK_INC);
    end else if (!txEn) begin
      running <= 1'b0;
      divCnt  <= '0;
      slotCnt <= '0;
      capBit  <= 1'b1;
      curInc  <= PHASE_W'(MARK_INC);
    end else if (!running) begin
      // first bit period opens with an idle mark
      running <= 1'b1;
      rateQ   <= rateSel;
    end else begin
      if (mclkEn) divCnt <= (divCnt == DIV_LAST) ? '0 : divCnt + 1'b1;
      if (sampleTick) begin
        if (slotCnt == midSlot) capBit <= txData;
        if (slotCnt == lastSlot) begin
          slotCnt <= '0;
          rateQ   <= rateSel;
          curInc  <= incFor(capBit, rateSel);
        end else begin
          slotCnt <= slotCnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/msk_tx_path.sv
module msk_tx_path
  import msk_tx_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  pathCmd_t                   cmd,
  output logic signed [SAMPLE_W-1:0] sampleOut
);
  localparam int IDX_W = PHASE_W - 2;
  localparam int QSIZE = 2 ** IDX_W;
  localparam int MAG_W = SAMPLE_W - 1;

  // integer sine approximation over half a cycle of 2*QSIZE steps
  function automatic int quarterSine(input int t);
    int n, num, den;
    n   = 2 * QSIZE;
    num = 16 * t * (n - t);
    den = 5 * n * n - 4 * t * (n - t);
    return (AMP * num + den / 2) / den;
  endfunction

  logic [MAG_W-1:0] qTab [QSIZE];
  for (genvar g = 0; g < QSIZE; g++) begin : g_tab
    assign qTab[g] = MAG_W'(quarterSine(g));
  end

  logic [PHASE_W-1:0] phase;
  logic [PHASE_W-1:0] nextPhase;
  logic [1:0]         quad;
  logic [IDX_W:0]     sel;
  logic [MAG_W-1:0]   mag;
  logic signed [SAMPLE_W-1:0] nextSample;

  always_comb begin
    nextPhase = phase + cmd.inc;
    quad      = nextPhase[PHASE_W-1 -: 2];
    sel       = quad[0] ? ((IDX_W+1)'(QSIZE) - {1'b0, nextPhase[IDX_W-1:0]})
                        : {1'b0, nextPhase[IDX_W-1:0]};
    mag       = sel[IDX_W] ? MAG_W'(AMP) : qTab[sel[IDX_W-1:0]];
    nextSample = quad[1] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= '0;
      sampleOut <= '0;
    end else if (cmd.clear) begin
      phase     <= '0;
      sampleOut <= '0;
    end else if (cmd.step) begin
      phase     <= nextPhase;
      sampleOut <= nextSample;
    end
  end
endmodule

// File: rtl/msk_tx_mod.sv
module msk_tx_mod
  import msk_tx_pkg::*;
#(
  parameter int SAMPLE_DIV = 384
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mclkEn,
  input  logic              txEn,
  input  logic              rateSel,
  input  logic              txData,
  output logic              txClk,
  output logic signed [7:0] sampleOut
);
  pathCmd_t cmd;

  msk_tx_ctrl #(.SAMPLE_DIV(SAMPLE_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .mclkEn(mclkEn), .txEn(txEn),
    .rateSel(rateSel), .txData(txData), .txClk(txClk), .cmd(cmd)
  );

  msk_tx_path u_path (
    .clk(clk), .rstN(rstN), .cmd(cmd), .sampleOut(sampleOut)
  );
endmodule

// File: rtl/msk_tx_checker.sv
module msk_tx_checker (
  input logic              clk,
  input logic              rstN,
  input logic              mclkEn,
  input logic              txEn,
  input logic              txClk,
  input logic signed [7:0] sampleOut
);
  AST_IDLE_PARKED: assert property (@(posedge clk) disable iff (!rstN)
    !txEn |=> (txClk && sampleOut == 8'sd0)); // R1

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (txEn && $past(txEn) && $past(rstN) && !mclkEn) |=> ($stable(sampleOut) && $stable(txClk))); // R10

  AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(txClk) && $past(txEn) && $past(rstN)) |-> $past(mclkEn)); // R5

  AST_FALL_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(txClk) && $past(txEn) && $past(rstN) && $past(txEn, 2) && $past(rstN, 2)) |-> $past(mclkEn)); // R2

  AST_NO_MOST_NEGATIVE: assert property (@(posedge clk) disable iff (!rstN)
    sampleOut != -8'sd128); // R7
endmodule

bind msk_tx_mod msk_tx_checker u_chk (
  .clk(clk), .rstN(rstN), .mclkEn(mclkEn), .txEn(txEn),
  .txClk(txClk), .sampleOut(sampleOut)
);

// File: tb/msk_tx_mod_bench.sv
module msk_tx_mod_bench;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mclkEn = 1'b0;
  logic txEn = 1'b0;
  logic rateSel = 1'b0;
  logic txData = 1'b1;
  logic txClk;
  logic signed [7:0] sampleOut;

  int nRun = 0;
  int nFail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  msk_tx_mod #(.SAMPLE_DIV(DIV)) u_msk_tx_mod (
    .clk(clk), .rstN(rstN), .mclkEn(mclkEn), .txEn(txEn),
    .rateSel(rateSel), .txData(txData), .txClk(txClk), .sampleOut(sampleOut)
  );

  function automatic int expSine(input int ph);
    real r;
    r = 127.0 * $sin(2.0 * 3.14159265358979 * ph / 256.0);
    return $rtoi(r >= 0.0 ? r + 0.5 : r - 0.5);
  endfunction

  function automatic int incOf(input bit b, input bit fast);
    return b ? 32 : (fast ? 64 : 48);
  endfunction

  function automatic int spbOf(input bit fast);
    return fast ? 4 : 8;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic checkSine(input string req, input int ph);
    int e, a;
    e = expSine(ph % 256);
    a = int'(sampleOut);
    check((a - e <= 1) && (e - a <= 1) && a != -128, req, a, e);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  endtask

  task automatic idleCheck(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      mclkEn  = 1'($urandom % 2);
      rateSel = 1'($urandom % 2);
      txData  = 1'($urandom % 2);
      check(txClk == 1'b1, "R1 txClk", int'(txClk), 1);
      check(sampleOut == 8'sd0, "R1/R11 sampleOut", int'(sampleOut), 0);
    end
  endtask

  task automatic runSegment(input int nBits, input bit startRate, input bit flips, input bit later);
    bit prevClk, first, mCap, lastMclk;
    int cnt, falls, bPhase, mInc, mSpb, bitNo;
    @(negedge clk);
    rateSel = startRate;
    txData  = 1'b1;
    txEn    = 1'b1;
    mclkEn  = 1'($urandom % 4 != 0);
    lastMclk = mclkEn;
    prevClk = 1'b1; first = 1; cnt = 0; falls = 0; bitNo = 0;
    bPhase = 0; mInc = 32; mSpb = spbOf(startRate); mCap = 1'b1;
    while (falls < nBits + 1) begin
      @(negedge clk);
      cnt += int'(lastMclk);
      if (prevClk && !txClk) begin
        if (first) begin
          first = 0;
          check(sampleOut == 8'sd0, later ? "R8/R11 start phase" : "R8 start phase", int'(sampleOut), 0);
        end else begin
          check(cnt == mSpb * DIV, flips ? "R2/R9/R10 bit length" : "R2/R10 bit length", cnt, mSpb * DIV);
          bPhase = (bPhase + mSpb * mInc) % 256;
          checkSine("R6 boundary phase", bPhase);
          mInc = incOf(mCap, rateSel);
          mSpb = spbOf(rateSel);
          bitNo++;
        end
        cnt = 0;
        falls++;
        txData = 1'($urandom % 2);
        if (flips && ($urandom % 3 == 0)) rateSel = ~rateSel;
      end else if (!prevClk && txClk) begin
        check(cnt == (mSpb / 2) * DIV, bitNo == 0 ? "R8 first rise" : "R5 rise point", cnt, (mSpb / 2) * DIV);
        if (bitNo == 0 && later)
          checkSine("R11 restart mid", (mSpb / 2) * mInc);
        else if (mInc == 32)
          checkSine("R3/R7 mark mid", bPhase + (mSpb / 2) * mInc);
        else
          checkSine("R4/R7 space mid", bPhase + (mSpb / 2) * mInc);
        mCap = txData;
        txData = 1'($urandom % 2);
      end
      prevClk = txClk;
      mclkEn = 1'($urandom % 4 != 0);
      lastMclk = mclkEn;
    end
    @(negedge clk);
    txEn = 1'b0;
    idleCheck(6);
  endtask

  initial begin
    void'($urandom(32'd20251));
    repeat (3) @(negedge clk);
    check(txClk == 1'b1, "R1 reset txClk", int'(txClk), 1);
    check(sampleOut == 8'sd0, "R1 reset sampleOut", int'(sampleOut), 0);
    rstN = 1'b1;
    idleCheck(10);
    runSegment(24, 1'b0, 1'b0, 1'b0);
    runSegment(24, 1'b1, 1'b0, 1'b1);
    runSegment(60, 1'b0, 1'b1, 1'b1);
    runSegment(40, 1'b1, 1'b1, 1'b1);
    // directed: a long stall of mclkEn while running must freeze outputs
    @(negedge clk);
    txEn = 1'b1; mclkEn = 1'b1;
    repeat (DIV * 3) @(negedge clk);
    mclkEn = 1'b0;
    @(negedge clk);
    begin
      logic signed [7:0] hold;
      logic holdClk;
      hold = sampleOut; holdClk = txClk;
      repeat (40) @(negedge clk);
      check(sampleOut == hold, "R10 stall sample", int'(sampleOut), int'(hold));
      check(txClk == holdClk, "R10 stall txClk", int'(txClk), int'(holdClk));
    end
    txEn = 1'b0;
    idleCheck(4);
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    nRun++;
    nFail++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    summary();
  end
endmodule